// File: doc/BRIEF.md
# Buck Regulator Fault Protection Supervisor

This block sits beside the control loop of a single-phase buck regulator. Its inputs are clean, synchronous comparator flags: overcurrent, short circuit, overvoltage, undervoltage, and a rising and a falling severe-overvoltage flag. It also receives the PWM request, a regulator enable and a supply-good (power-on-reset) bit. From these it drives the high-side and low-side gate enables and a power-good bit, and it reports a 3-bit code for the fault that caused the shutdown.

Each ordinary fault must persist for its own number of clock cycles before the block acts. Once a fault qualifies, the block latches a shutdown. A latched ordinary fault is released by dropping either the enable or supply-good. A severe overvoltage needs no qualification. It latches at once, even on top of an ordinary fault, and holds the high side off. While it is latched, the low-side gate follows a hysteresis between the two severe flags. Only a supply-good drop releases it.

Top module: `vr_fault_guard`

## Requirements
- R1: With supply-good and enable high and nothing latched, hs_en_o equals pwm_i, ls_en_o equals the inverse of pwm_i, pgood_o is 1 and fault_code_o is 0.
- R2: If oc_i is high at OC_CYC consecutive clock edges, the fault latches at the last of those edges and fault_code_o becomes 1.
- R3: If sc_i is high at SC_CYC consecutive edges, the fault latches and fault_code_o becomes 2.
- R4: Overvoltage (ov_i) qualifies after OV_CYC consecutive edges and gives code 3. Undervoltage (uv_i) qualifies after UV_CYC consecutive edges and gives code 4.
- R5: A persistence count restarts whenever its flag is low at an edge, or whenever supply-good or enable is low. A flag held for one edge fewer than its limit latches nothing.
- R6: While an ordinary fault (codes 1 to 4) is latched, hs_en_o, ls_en_o and pgood_o are all 0. The latch holds after the flag that caused it goes low.
- R7: Enable low at a clock edge clears an ordinary fault. Normal operation per R1 resumes when enable returns high.
- R8: Supply-good low at a clock edge clears every latched fault. The code reads 0 in the following cycle.
- R9: With supply-good high, sov_hi_i high at one edge latches the severe fault at that edge. In the next cycle fault_code_o is 5, hs_en_o is 0, pgood_o is 0 and ls_en_o is 1.
- R10: While the severe fault is latched, ls_en_o turns on after an edge that sees sov_hi_i and turns off after an edge that sees only sov_lo_i. It keeps toggling this way.
- R11: Enable cycling does not clear the severe fault (code stays 5). A supply-good cycle does clear it.
- R12: A severe fault can latch while an ordinary fault is already latched. It then reports code 5 and takes control of ls_en_o.
- R13: The code reports the first fault only. If ordinary faults qualify at the same edge, the priority is short circuit, then overcurrent, then overvoltage, then undervoltage. Faults that qualify later do not change the code.
- R14: hs_en_o and ls_en_o are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vdd_good_i | input | 1 | Supply-good; low acts as power-on reset for all faults |
| vr_en_i | input | 1 | Regulator enable |
| pwm_i | input | 1 | PWM request from the loop |
| oc_i | input | 1 | Overcurrent flag |
| sc_i | input | 1 | Short-circuit flag |
| ov_i | input | 1 | Overvoltage flag |
| uv_i | input | 1 | Undervoltage flag |
| sov_hi_i | input | 1 | Output above the upper severe threshold |
| sov_lo_i | input | 1 | Output below the lower severe release threshold |
| hs_en_o | output | 1 | High-side gate enable |
| ls_en_o | output | 1 | Low-side gate enable |
| pgood_o | output | 1 | Power good |
| fault_code_o | output | 3 | 0 none, 1 OC, 2 SC, 3 OV, 4 UV, 5 severe OV |

## Verification
The collisions that matter are two qualification timers expiring at the same edge, and a severe overvoltage arriving while an ordinary fault is already latched. For the first case, the bench starts overcurrent earlier than short circuit by exactly the difference of their limits, so both qualify at the same edge. It then expects code 2, and expects the code to stay 2 when a later overvoltage also qualifies. For the second case, the bench latches an overcurrent and then pulses the upper severe flag. It expects code 5 with the low side switched on, which shows the severe path overriding the frozen ordinary latch in one cycle.

// File: rtl/vr_fault_pkg.sv
package vr_fault_pkg;

  typedef enum logic [2:0] {
    FC_NONE = 3'd0,
    FC_OC   = 3'd1,
    FC_SC   = 3'd2,
    FC_OV   = 3'd3,
    FC_UV   = 3'd4,
    FC_SEV  = 3'd5
  } fault_code_e;

  // qualified faults; index 0 has the highest priority
  localparam int unsigned NUM_QUAL = 4;

endpackage

// File: rtl/persist_qual.sv
module persist_qual #(
  parameter int unsigned LIMIT = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic flag_i,
  output logic hit_o
);

  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign hit_o = arm_i && flag_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!arm_i || !flag_i) cnt_q <= '0;
    else if (cnt_q != LAST)     cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/sev_ovp_ctrl.sv
module sev_ovp_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vdd_good_i,
  input  logic hi_i,
  input  logic lo_i,
  output logic active_o,
  output logic ls_o
);

  logic act_q, ls_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      ls_q  <= 1'b0;
    end else if (!vdd_good_i) begin
      act_q <= 1'b0;
      ls_q  <= 1'b0;
    end else begin
      if (hi_i) act_q <= 1'b1;
      // upper threshold wins if both flags are seen
      if (hi_i)      ls_q <= 1'b1;
      else if (lo_i) ls_q <= 1'b0;
    end
  end

  assign active_o = act_q;
  assign ls_o     = ls_q;

endmodule

// File: rtl/vr_fault_guard.sv
module vr_fault_guard
  import vr_fault_pkg::*;
#(
  parameter int unsigned OC_CYC = 6000,
  parameter int unsigned SC_CYC = 4,
  parameter int unsigned OV_CYC = 50000,
  parameter int unsigned UV_CYC = 50000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       vdd_good_i,
  input  logic       vr_en_i,
  input  logic       pwm_i,
  input  logic       oc_i,
  input  logic       sc_i,
  input  logic       ov_i,
  input  logic       uv_i,
  input  logic       sov_hi_i,
  input  logic       sov_lo_i,
  output logic       hs_en_o,
  output logic       ls_en_o,
  output logic       pgood_o,
  output logic [2:0] fault_code_o
);

  localparam int unsigned LIM [NUM_QUAL] = '{SC_CYC, OC_CYC, OV_CYC, UV_CYC};
  localparam fault_code_e CODE [NUM_QUAL] = '{FC_SC, FC_OC, FC_OV, FC_UV};

  logic                armed;
  logic [NUM_QUAL-1:0] flags, hits;
  fault_code_e         new_code, code_q;
  logic                sev_act, sev_ls, run;

  assign armed = vdd_good_i && vr_en_i;
  assign flags = {uv_i, ov_i, oc_i, sc_i};

  for (genvar g = 0; g < NUM_QUAL; g++) begin : g_qual
    persist_qual #(.LIMIT(LIM[g])) u_qual (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .arm_i  (armed),
      .flag_i (flags[g]),
      .hit_o  (hits[g])
    );
  end

  always_comb begin
    new_code = FC_NONE;
    for (int i = NUM_QUAL - 1; i >= 0; i--) begin
      if (hits[i]) new_code = CODE[i];
    end
  end

  // first ordinary fault; freezes until enable or supply drops
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              code_q <= FC_NONE;
    else if (!armed)          code_q <= FC_NONE;
    else if (code_q == FC_NONE) code_q <= new_code;
  end

  sev_ovp_ctrl u_sev (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vdd_good_i (vdd_good_i),
    .hi_i       (sov_hi_i),
    .lo_i       (sov_lo_i),
    .active_o   (sev_act),
    .ls_o       (sev_ls)
  );

  assign run          = armed && (code_q == FC_NONE) && !sev_act;
  assign hs_en_o      = run && pwm_i;
  assign ls_en_o      = sev_act ? sev_ls : (run && !pwm_i);
  assign pgood_o      = run;
  assign fault_code_o = sev_act ? FC_SEV : code_q;

endmodule

// File: rtl/vr_fault_guard_chk.sv
module vr_fault_guard_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       vdd_good_i,
  input logic       vr_en_i,
  input logic       pwm_i,
  input logic       oc_i,
  input logic       sc_i,
  input logic       ov_i,
  input logic       uv_i,
  input logic       sov_hi_i,
  input logic       sov_lo_i,
  input logic       hs_en_o,
  input logic       ls_en_o,
  input logic       pgood_o,
  input logic [2:0] fault_code_o
);

  // R14
  no_shoot_through_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_en_o && ls_en_o));

  // R6
  ord_fault_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_code_o inside {3'd1, 3'd2, 3'd3, 3'd4}) |-> (!hs_en_o && !ls_en_o && !pgood_o));

  // R8
  vdd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vdd_good_i |=> (fault_code_o == 3'd0));

  // R9
  sev_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vdd_good_i && sov_hi_i) |=> (fault_code_o == 3'd5 && ls_en_o && !hs_en_o && !pgood_o));

  // R10
  sev_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_code_o == 3'd5 && vdd_good_i && sov_lo_i && !sov_hi_i) |=> !ls_en_o);

  // R13
  code_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vdd_good_i && vr_en_i && fault_code_o != 3'd0 && !sov_hi_i) |=> $stable(fault_code_o));

endmodule

bind vr_fault_guard vr_fault_guard_chk u_chk (.*);

// File: tb/vr_fault_guard_tb.sv
module vr_fault_guard_tb;

  localparam int unsigned OC = 12;
  localparam int unsigned SC = 3;
  localparam int unsigned OV = 20;
  localparam int unsigned UV = 16;

  logic clk = 1'b0;
  logic rst_ni, vdd, en, pwm, oc, sc, ov, uv, shi, slo;
  logic hs, ls, pg;
  logic [2:0] code;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  vr_fault_guard #(.OC_CYC(OC), .SC_CYC(SC), .OV_CYC(OV), .UV_CYC(UV)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .vdd_good_i(vdd), .vr_en_i(en), .pwm_i(pwm),
    .oc_i(oc), .sc_i(sc), .ov_i(ov), .uv_i(uv), .sov_hi_i(shi), .sov_lo_i(slo),
    .hs_en_o(hs), .ls_en_o(ls), .pgood_o(pg), .fault_code_o(code)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int outs();
    return {hs, ls, pg, code};
  endfunction

  // {hs,ls,pg,code}
  function automatic int pack(input int h, input int l, input int p, input int c);
    return (h << 5) | (l << 4) | (p << 3) | c;
  endfunction

  task automatic cyc_en();
    @(negedge clk) en = 1'b0;
    @(negedge clk) en = 1'b1;
  endtask

  task automatic cyc_vdd();
    @(negedge clk) vdd = 1'b0;
    @(negedge clk) chk("R8 code cleared", code, 0);
    vdd = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_idle();
    @(negedge clk) pwm = 1'b0;
    #1 chk("R1 pwm low", outs(), pack(0, 1, 1, 0));
    pwm = 1'b1;
    #1 chk("R1 pwm high", outs(), pack(1, 0, 1, 0));
  endtask

  task automatic t_oc();
    @(negedge clk) oc = 1'b1;
    repeat (8) @(posedge clk);
    @(negedge clk) oc = 1'b0;
    @(negedge clk) oc = 1'b1;
    repeat (OC - 1) @(posedge clk);
    @(negedge clk) chk("R5 restart no latch", pg, 1);
    @(posedge clk);
    @(negedge clk) chk("R2 oc latch", outs(), pack(0, 0, 0, 1));
    oc = 1'b0;
    pwm = 1'b0;
    repeat (3) @(negedge clk);
    #1 chk("R6 held after flag low", outs(), pack(0, 0, 0, 1));
    cyc_en();
    @(negedge clk) chk("R7 enable cycle clears", outs(), pack(0, 1, 1, 0));
    pwm = 1'b1;
  endtask

  task automatic t_qual(input int idx, input int lim, input int exp, input string req);
    @(negedge clk);
    case (idx)
      0: sc = 1'b1;
      1: ov = 1'b1;
      default: uv = 1'b1;
    endcase
    repeat (lim - 1) @(posedge clk);
    @(negedge clk) chk({req, " not yet"}, pg, 1);
    @(posedge clk);
    @(negedge clk) chk({req, " latch"}, outs(), pack(0, 0, 0, exp));
    sc = 1'b0; ov = 1'b0; uv = 1'b0;
    cyc_vdd();
    chk({req, " R8 back to run"}, outs(), pack(1, 0, 1, 0));
  endtask

  task automatic t_prio();
    @(negedge clk) oc = 1'b1;
    repeat (OC - SC) @(posedge clk);
    @(negedge clk) sc = 1'b1;
    repeat (SC) @(posedge clk);
    @(negedge clk) chk("R13 same-edge priority", code, 2);
    oc = 1'b0; sc = 1'b0; ov = 1'b1;
    repeat (OV + 2) @(negedge clk);
    chk("R13 later fault ignored", code, 2);
    ov = 1'b0;
    cyc_en();
    @(negedge clk) chk("R7 run after prio", pg, 1);
  endtask

  task automatic t_sev();
    @(negedge clk) shi = 1'b1;
    @(negedge clk) chk("R9 severe entry", outs(), pack(0, 1, 0, 5));
    shi = 1'b0; slo = 1'b1;
    @(negedge clk) chk("R10 low side off", ls, 0);
    slo = 1'b0;
    @(negedge clk) chk("R10 low side stays off", ls, 0);
    shi = 1'b1;
    @(negedge clk) chk("R10 low side on again", ls, 1);
    shi = 1'b0;
    chk("R14 no overlap in severe", hs & ls, 0);
    cyc_en();
    @(negedge clk) chk("R11 enable does not clear", code, 5);
    cyc_vdd();
    chk("R11 supply cycle clears", outs(), pack(1, 0, 1, 0));
  endtask

  task automatic t_sev_over();
    @(negedge clk) pwm = 1'b0; oc = 1'b1;
    repeat (OC) @(posedge clk);
    @(negedge clk) chk("R12 oc latched first", outs(), pack(0, 0, 0, 1));
    oc = 1'b0; shi = 1'b1;
    @(negedge clk) chk("R12 severe overrides", outs(), pack(0, 1, 0, 5));
    shi = 1'b0;
    cyc_vdd();
    chk("R8 clear after overlap", outs(), pack(0, 1, 1, 0));
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    rst_ni = 1'b0; vdd = 1'b1; en = 1'b1; pwm = 1'b0;
    oc = 1'b0; sc = 1'b0; ov = 1'b0; uv = 1'b0; shi = 1'b0; slo = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_idle();
    t_oc();
    t_qual(0, SC, 2, "R3 sc");
    t_qual(1, OV, 3, "R4 ov");
    t_qual(2, UV, 4, "R4 uv");
    t_prio();
    t_sev();
    t_sev_over();
    finish_run();
  end

endmodule